// File: doc/BRIEF.md
# Dual-Core Interrupt Source Router

This block sits between a bank of level-sensitive peripheral interrupt lines and two processor cores. Every source line owns one halfword control register holding a two-bit core-select mask. A line's level is passed to a core's interrupt vector only while the matching mask bit is set. Otherwise that core sees the line low. After reset no source reaches either core until software writes a mask.

The control registers sit in a dense window inside a 4 KB halfword-addressed region. Source n uses byte offset `WIN_BASE + 2*n`, and the window ends just below `WIN_BASE + 2*NUM_SRC`. Software reads a register back with a combinational halfword read. Accesses outside the window, and odd byte addresses, read as zero and are dropped on write. Incoming lines pass through a two-flop synchronizer before gating, so each core output is a clean registered level ANDed with a registered route bit.

Top module: `irq_core_router`

## Requirements
- R1: After reset every route bit is clear: both core outputs are all zero even with every input high, and every control register reads 0.
- R2: A halfword write to byte offset 0x880 + 2*n (n from 0 to 111) sets source n's mask. Data bit 0 enables core 0 and data bit 1 enables core 1. A read of the same offset returns the mask in bits 1:0.
- R3: Bits 15:2 of a control register always read 0, whatever was written to them.
- R4: Output bit n of core k is high exactly when the synchronized input n is high and source n's route bit for core k is set.
- R5: A route change is visible at the core outputs in the cycle right after the clock edge that takes the write.
- R6: An input change reaches the core outputs after two rising clock edges, and not after one.
- R7: A halfword access below 0x880, at 0x880 + 224 or above, up to 0xFFE, reads 0. A write there changes no route bit and no output.
- R8: An odd byte address inside the window reads 0, and a write to it changes no route bit.
- R9: A write to one source's register leaves every other source's mask unchanged.
- R10: A mask of 3 delivers the source to both cores at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Halfword access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte offset inside the 4 KB region |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational, zero when not reading |
| irq_src | input | NUM_SRC (112) | Level-sensitive source lines |
| irq_core0 | output | NUM_SRC (112) | Gated lines to core 0 |
| irq_core1 | output | NUM_SRC (112) | Gated lines to core 1 |

## Verification
The bench builds the router with its default values: 112 sources, a 12-bit address, the window at 0x880 and two synchronizer stages. These defaults make source 111 the last real register, and put the first address past the window at exactly 0x960. The bench tests both edges of the window, 0x87E and 0x960, as well as the top of the region at 0xFFE. With two stages, the bench can also tell an input latency of one edge apart from two.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int HALF_W = 16;
    localparam int MASK_W = 2;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_RD   = 2'd1,
        ACC_WR   = 2'd2
    } acc_t;

endpackage

// File: rtl/irq_route_sync.sv
module irq_route_sync #(
    parameter int NUM_SRC = 112,
    parameter int STAGES  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] async_in,
    output logic [NUM_SRC-1:0] sync_out
);

    typedef struct packed {
        logic [STAGES-1:0][NUM_SRC-1:0] stg;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.stg[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            s_d.stg[i] = s_q.stg[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sync_out = s_q.stg[STAGES-1];

    generate
        if (STAGES == 2) begin : g_lat_chk
            AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n, 1) && $past(rst_n, 2)) |-> (sync_out == $past(async_in, 2))); // R6
        end
    endgenerate

endmodule

// File: rtl/irq_route_decode.sv
module irq_route_decode
    import irq_route_pkg::*;
#(
    parameter int               NUM_SRC  = 112,
    parameter int               ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] WIN_BASE = 12'h880
) (
    input  logic                       sel,
    input  logic                       wr,
    input  logic [ADDR_W-1:0]          addr,
    output acc_t                       kind,
    output logic                       hit,
    output logic [$clog2(NUM_SRC)-1:0] idx
);

    localparam int IDX_W   = $clog2(NUM_SRC);
    localparam int WIN_END = int'(WIN_BASE) + 2 * NUM_SRC;

    logic [ADDR_W-1:0] off;
    logic              in_range;
    logic              unused_off;

    always_comb begin
        if (!sel) begin
            kind = ACC_NONE;
        end else if (wr) begin
            kind = ACC_WR;
        end else begin
            kind = ACC_RD;
        end
    end

    assign off      = addr - WIN_BASE;
    assign in_range = (int'(addr) >= int'(WIN_BASE)) && (int'(addr) < WIN_END);
    assign hit      = sel && in_range && !addr[0];
    assign idx      = off[IDX_W:1];

    assign unused_off = ^{off[ADDR_W-1:IDX_W+1], off[0]};

endmodule

// File: rtl/irq_route_table.sv
module irq_route_table
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC = 112
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  acc_t                       kind,
    input  logic                       hit,
    input  logic [$clog2(NUM_SRC)-1:0] idx,
    input  logic [MASK_W-1:0]          wbits,
    output logic [NUM_SRC-1:0]         route_c0,
    output logic [NUM_SRC-1:0]         route_c1,
    output logic [MASK_W-1:0]          rd_bits
);

    typedef struct packed {
        logic [NUM_SRC-1:0] c0;
        logic [NUM_SRC-1:0] c1;
    } route_t;

    route_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (kind == ACC_WR && hit) begin
            r_d.c0[idx] = wbits[0];
            r_d.c1[idx] = wbits[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rd_bits = '0;
        if (hit) begin
            rd_bits = {r_q.c1[idx], r_q.c0[idx]};
        end
    end

    assign route_c0 = r_q.c0;
    assign route_c1 = r_q.c1;

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (route_c0 == '0 && route_c1 == '0)); // R1

    AST_WRITE_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_WR && hit) |=> (route_c0[$past(idx)] == $past(wbits[0])
                                     && route_c1[$past(idx)] == $past(wbits[1]))); // R2

    AST_MISS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_WR && !hit) |=> ($stable(route_c0) && $stable(route_c1))); // R7

endmodule

// File: rtl/irq_core_router.sv
module irq_core_router
    import irq_route_pkg::*;
#(
    parameter int               NUM_SRC     = 112,
    parameter int               ADDR_W      = 12,
    parameter logic [ADDR_W-1:0] WIN_BASE    = 12'h880,
    parameter int               SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [15:0]        bus_wdata,
    output logic [15:0]        bus_rdata,
    input  logic [NUM_SRC-1:0] irq_src,
    output logic [NUM_SRC-1:0] irq_core0,
    output logic [NUM_SRC-1:0] irq_core1
);

    localparam int IDX_W = $clog2(NUM_SRC);

    acc_t               acc_kind;
    logic               acc_hit;
    logic [IDX_W-1:0]   acc_idx;
    logic [MASK_W-1:0]  rd_mask;
    logic [NUM_SRC-1:0] route_c0;
    logic [NUM_SRC-1:0] route_c1;
    logic [NUM_SRC-1:0] src_sync;
    logic               unused_wdata;

    irq_route_decode #(
        .NUM_SRC (NUM_SRC),
        .ADDR_W  (ADDR_W),
        .WIN_BASE(WIN_BASE)
    ) i_decode (
        .sel (bus_sel),
        .wr  (bus_wr),
        .addr(bus_addr),
        .kind(acc_kind),
        .hit (acc_hit),
        .idx (acc_idx)
    );

    irq_route_table #(
        .NUM_SRC(NUM_SRC)
    ) i_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .kind    (acc_kind),
        .hit     (acc_hit),
        .idx     (acc_idx),
        .wbits   (bus_wdata[MASK_W-1:0]),
        .route_c0(route_c0),
        .route_c1(route_c1),
        .rd_bits (rd_mask)
    );

    irq_route_sync #(
        .NUM_SRC(NUM_SRC),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(irq_src),
        .sync_out(src_sync)
    );

    assign bus_rdata = (acc_kind == ACC_RD && acc_hit)
                       ? {{(HALF_W-MASK_W){1'b0}}, rd_mask} : '0;

    assign irq_core0 = src_sync & route_c0;
    assign irq_core1 = src_sync & route_c1;

    assign unused_wdata = ^bus_wdata[HALF_W-1:MASK_W];

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[HALF_W-1:MASK_W] == '0); // R3

    AST_MISS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && !acc_hit) |-> bus_rdata == '0); // R7

    AST_CORE0_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_core0 & ~src_sync) == '0); // R4

endmodule

// File: tb/test_irq_core_router.sv
`timescale 1ns/1ps
module test_irq_core_router;

    localparam int N = 112;
    localparam real TCK = 4.0;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          bus_sel, bus_wr;
    logic [11:0]   bus_addr;
    logic [15:0]   bus_wdata, bus_rdata;
    logic [N-1:0]  irq_src, irq_core0, irq_core1;
    logic [N-1:0]  m0, m1;

    int n_chk = 0;
    int n_err = 0;

    always #(TCK/2) clk = ~clk;

    irq_core_router i_irq_core_router (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_src(irq_src), .irq_core0(irq_core0), .irq_core1(irq_core1)
    );

    task automatic chk(string req, logic [127:0] got, logic [127:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic bus_write(logic [11:0] a, logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [11:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic set_route(int n, logic [15:0] d);
        bus_write(12'h880 + 12'(2 * n), d);
        m0[n] = d[0];
        m1[n] = d[1];
    endtask

    task automatic chk_reg(string req, int n);
        logic [15:0] d;
        bus_read(12'h880 + 12'(2 * n), d);
        chk(req, 128'(d), 128'({m1[n], m0[n]}));
    endtask

    task automatic settle_src(logic [N-1:0] v);
        @(negedge clk);
        irq_src = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic chk_outputs_all_high(string req);
        settle_src('1);
        chk({req, " core0"}, 128'(irq_core0), 128'(m0));
        chk({req, " core1"}, 128'(irq_core1), 128'(m1));
    endtask

    task automatic t_reset();
        logic [15:0] d;
        settle_src('1);
        chk("R1 core0 after reset", 128'(irq_core0), 128'(0));
        chk("R1 core1 after reset", 128'(irq_core1), 128'(0));
        bus_read(12'h880, d);
        chk("R1 reg0 after reset", 128'(d), 128'(0));
        bus_read(12'h95E, d);
        chk("R1 reg111 after reset", 128'(d), 128'(0));
        settle_src('0);
    endtask

    task automatic t_readback();
        set_route(5, 16'h0001);
        chk_reg("R2 src5 mask1", 5);
        set_route(111, 16'h0002);
        chk_reg("R2 src111 mask2", 111);
        set_route(0, 16'h0003);
        chk_reg("R2 src0 mask3", 0);
    endtask

    task automatic t_upper();
        logic [15:0] d;
        set_route(7, 16'hFFFC);
        bus_read(12'h88E, d);
        chk("R3 upper bits only", 128'(d), 128'(0));
        set_route(7, 16'hFFFF);
        bus_read(12'h88E, d);
        chk("R3 all ones reads 3", 128'(d), 128'(3));
    endtask

    task automatic t_gating();
        logic [N-1:0] v;
        v = '0; v[5] = 1'b1; v[111] = 1'b1;
        settle_src(v);
        chk("R4 core0 pattern A", 128'(irq_core0), 128'(v & m0));
        chk("R4 core1 pattern A", 128'(irq_core1), 128'(v & m1));
        v = '0; v[0] = 1'b1; v[20] = 1'b1;
        settle_src(v);
        chk("R10 core0 both", 128'(irq_core0[0]), 128'(1));
        chk("R10 core1 both", 128'(irq_core1[0]), 128'(1));
        chk("R4 unrouted src20", 128'({irq_core1[20], irq_core0[20]}), 128'(0));
        settle_src('0);
    endtask

    task automatic t_timing();
        logic [N-1:0] v;
        v = '0; v[30] = 1'b1;
        settle_src(v);
        chk("R5 before route", 128'(irq_core0[30]), 128'(0));
        set_route(30, 16'h0001);
        chk("R5 cycle after write on", 128'(irq_core0[30]), 128'(1));
        set_route(30, 16'h0000);
        chk("R5 cycle after write off", 128'(irq_core0[30]), 128'(0));
        settle_src('0);
    endtask

    task automatic t_latency();
        set_route(40, 16'h0002);
        @(negedge clk);
        irq_src[40] = 1'b1;
        @(negedge clk);
        chk("R6 rise not after one edge", 128'(irq_core1[40]), 128'(0));
        @(negedge clk);
        chk("R6 rise after two edges", 128'(irq_core1[40]), 128'(1));
        irq_src[40] = 1'b0;
        @(negedge clk);
        chk("R6 fall not after one edge", 128'(irq_core1[40]), 128'(1));
        @(negedge clk);
        chk("R6 fall after two edges", 128'(irq_core1[40]), 128'(0));
    endtask

    task automatic t_window();
        logic [15:0] d;
        bus_write(12'h960, 16'h0003);
        bus_write(12'h87E, 16'h0003);
        bus_write(12'hFFE, 16'h0003);
        bus_read(12'h960, d);
        chk("R7 read 0x960", 128'(d), 128'(0));
        bus_read(12'h87E, d);
        chk("R7 read 0x87E", 128'(d), 128'(0));
        bus_read(12'hFFE, d);
        chk("R7 read 0xFFE", 128'(d), 128'(0));
        chk_reg("R7 src111 unchanged", 111);
        chk_outputs_all_high("R7 outputs unchanged");
        settle_src('0);
    endtask

    task automatic t_odd();
        logic [15:0] d;
        bus_write(12'h881, 16'h0000);
        chk_reg("R8 src0 kept after odd write", 0);
        bus_read(12'h881, d);
        chk("R8 odd read zero", 128'(d), 128'(0));
    endtask

    task automatic t_indep();
        set_route(50, 16'h0003);
        chk_reg("R9 src49 untouched", 49);
        chk_reg("R9 src51 untouched", 51);
        chk_outputs_all_high("R9 full map");
        settle_src('0);
    endtask

    initial begin
        #(TCK * 200000);
        n_err++;
        $display("FAIL watchdog expired, all requirements: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        bus_addr = '0; bus_wdata = '0; irq_src = '0;
        m0 = '0; m1 = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_readback();
        t_upper();
        t_gating();
        t_timing();
        t_latency();
        t_window();
        t_odd();
        t_indep();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule